// File: doc/BRIEF.md
# Serial Flash Command Front-End

This block sits behind the serial pins of a flash-style slave and works out, for each chip-select frame, whether the command that arrived is one the array should carry out. It samples chip select, serial clock and data-in with the fast system clock. It shifts bits in most significant bit first, takes the first byte as the opcode and the next three bytes as the address, and counts how many bits the frame held. Nothing is decided while the frame is still open. The decision is made only when chip select goes high again.

Once the frame has closed, the block checks the frame length against the rules for that command class. It then applies the busy lockout, the write-enable latch and the block-protect window selected by a three-bit level input. If the command passes every check, the block emits a single-cycle execute strobe together with the decoded command code, the captured address and the data byte count. A program or erase that aims inside the protected window produces no strobe. Instead it raises a sticky reject flag.

The controller is a three-state machine. `ST_IDLE` waits while chip select is high. The transition *open* (chip select seen low) leads to `ST_FRAME`, where bits are collected. The transition *close* (chip select seen rising) snapshots the frame and leads to `ST_DECIDE`. The transition *retire* leads back to `ST_IDLE` after one cycle, and in that cycle the strobe, the latch and the flag are updated.

Top module: `serial_cmd_front`

## Requirements
- R1: Bits are taken most significant first. The first 8 bits after chip select falls form the opcode. The next 24 bits form the address, and the first of them is address bit 23. For codes 1, 2, 9, 10 and 11, `exec_addr` carries this address.
- R2: Opcodes are decoded as follows, and an accepted command puts its code on `exec_op`: 03h→1 (read), 0Bh→2 (fast read), 05h→3 (status read), ABh→4 (wake), 9Fh→5 (identity read), 06h→6 (latch set), 04h→7 (latch clear), 01h→8 (status write), 02h→9 (program), 20h→10 (4 KB sector erase), D8h→11 (64 KB block erase), C7h→12 (full erase), B9h→13 (sleep).
- R3: For codes 6 to 13, a frame whose bit count is not a multiple of 8 is dropped. No strobe is issued, and the latch and the flag keep their values.
- R4: A program frame needs at least 40 bits and a status write needs at least 16. A shorter frame is dropped. `exec_nbytes` is the number of whole bytes after the header, where the header is 32 bits for codes 1, 2, 9, 10 and 11 and 8 bits for all other codes.
- R5: A sector erase or block erase is accepted only with exactly 32 bits. Any other count is dropped.
- R6: Read-class frames may end on any bit. Codes 3, 4 and 5 need at least 8 bits. Codes 1 and 2 need at least 32 bits.
- R7: While `wr_busy` is high, codes 1, 2 and 8 to 12 are dropped. The other codes are still accepted.
- R8: The latch `wel` is set by an accepted code 6. It is cleared by an accepted code 7 and by any issued code from 8 to 12. Codes 8 to 12 are dropped while `wel` is low.
- R9: Let F be 80000h and let the protected range be the addresses below a limit L. The limit is L=0 for `bp_lvl`=0, L=F for `bp_lvl`=7, and L=F−(1000h<<`bp_lvl`) otherwise. The check uses address bits [18:0] and is made against the program address, the 4 KB-aligned sector base or the 64 KB-aligned block base. A full erase counts as a hit whenever `bp_lvl`≠0. A hit on a command that passed R3 to R8 issues no strobe and sets `prot_reject`. Only an accepted code 6 clears `prot_reject`.
- R10: `exec_stb` is high for exactly one cycle for each accepted frame, within 8 clock cycles of chip select rising at the pin. A frame that is not accepted gives no pulse.
- R11: A frame of fewer than 8 bits, or one whose opcode is not listed in R2, has no effect.
- R12: After reset, `exec_stb`, `exec_op`, `exec_addr`, `exec_nbytes`, `wel` and `prot_reject` are all zero.
- R13: A program frame that ends part-way through a byte leaves `wel` set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 6 times the serial clock rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_cs_n | input | 1 | Serial chip select, active low |
| spi_sclk | input | 1 | Serial clock; data is taken on its rising edge |
| spi_di | input | 1 | Serial data in |
| bp_lvl | input | 3 | Block-protect level |
| wr_busy | input | 1 | A write, program or erase cycle is in progress |
| exec_stb | output | 1 | One-cycle execute pulse |
| exec_op | output | 4 | Decoded command code (R2) |
| exec_addr | output | 24 | Captured address |
| exec_nbytes | output | 9 | Whole bytes after the header |
| wel | output | 1 | Write-enable latch |
| prot_reject | output | 1 | Sticky protection-reject flag |

## Verification
The bench sweeps every opcode, including two unlisted ones, over frame lengths that land just short of, exactly on and just past the byte and header boundaries, each with the latch both clear and set. A design that judged frames by the opcode alone would fire on 7-bit or 47-bit frames, and an off-by-one in the erase rule would accept 33-bit or 40-bit erases. The bench repeats a subset of commands with the busy input held high, where a missing lockout would let reads and writes through. Every protect level is then crossed with addresses at 0, at L−1, at L and at the top of the array, so that a wrong limit or a missing sector or block alignment shows up as a strobe or a flag on the wrong side of the boundary.

// File: rtl/sfc_pkg.sv
package sfc_pkg;

    typedef enum logic [3:0] {
        K_NONE   = 4'd0,
        K_READ   = 4'd1,
        K_FREAD  = 4'd2,
        K_RSTAT  = 4'd3,
        K_WAKE   = 4'd4,
        K_RID    = 4'd5,
        K_WEN    = 4'd6,
        K_WDIS   = 4'd7,
        K_WSTAT  = 4'd8,
        K_PROG   = 4'd9,
        K_SERASE = 4'd10,
        K_BERASE = 4'd11,
        K_CERASE = 4'd12,
        K_SLEEP  = 4'd13
    } cmd_kind_t;

    function automatic cmd_kind_t decode_op(input logic [7:0] op);
        cmd_kind_t k;
        case (op)
            8'h03:   k = K_READ;
            8'h0B:   k = K_FREAD;
            8'h05:   k = K_RSTAT;
            8'hAB:   k = K_WAKE;
            8'h9F:   k = K_RID;
            8'h06:   k = K_WEN;
            8'h04:   k = K_WDIS;
            8'h01:   k = K_WSTAT;
            8'h02:   k = K_PROG;
            8'h20:   k = K_SERASE;
            8'hD8:   k = K_BERASE;
            8'hC7:   k = K_CERASE;
            8'hB9:   k = K_SLEEP;
            default: k = K_NONE;
        endcase
        return k;
    endfunction

    // commands that alter the array or the status register
    function automatic logic is_write(input cmd_kind_t k);
        return k inside {K_WSTAT, K_PROG, K_SERASE, K_BERASE, K_CERASE};
    endfunction

    // commands that must end on a byte boundary
    function automatic logic is_strict(input cmd_kind_t k);
        return is_write(k) || (k inside {K_WEN, K_WDIS, K_SLEEP});
    endfunction

    // commands refused while a write cycle runs
    function automatic logic is_locked(input cmd_kind_t k);
        return is_write(k) || (k inside {K_READ, K_FREAD});
    endfunction

    // commands that carry a 24-bit address
    function automatic logic has_addr(input cmd_kind_t k);
        return k inside {K_READ, K_FREAD, K_PROG, K_SERASE, K_BERASE};
    endfunction

endpackage

// File: rtl/sfc_sync.sv
module sfc_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cs_n,
    input  logic sclk,
    input  logic di,
    output logic cs_hi,
    output logic cs_rise,
    output logic sclk_rise,
    output logic di_s
);
    localparam int LAST = STAGES;

    // bit 2: chip select, bit 1: serial clock, bit 0: data
    logic [2:0] pipe [LAST+1];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i <= LAST; i++) pipe[i] <= 3'b100;
        end else begin
            pipe[0] <= {cs_n, sclk, di};
            for (int i = 1; i <= LAST; i++) pipe[i] <= pipe[i-1];
        end
    end

    assign cs_hi     = pipe[LAST-1][2];
    assign cs_rise   = pipe[LAST-1][2] & ~pipe[LAST][2];
    assign sclk_rise = pipe[LAST-1][1] & ~pipe[LAST][1];
    assign di_s      = pipe[LAST-1][0];

endmodule

// File: rtl/sfc_shifter.sv
module sfc_shifter #(
    parameter int CNT_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cs_hi,
    input  logic             bit_stb,
    input  logic             bit_in,
    output logic [CNT_W-1:0] bit_cnt,
    output logic [7:0]       opcode,
    output logic [23:0]      addr
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;
    localparam logic [CNT_W-1:0] AT_OP   = CNT_W'(7);
    localparam logic [CNT_W-1:0] AT_ADR  = CNT_W'(31);

    logic [31:0] sh;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh      <= '0;
            bit_cnt <= '0;
            opcode  <= '0;
            addr    <= '0;
        end else if (cs_hi) begin
            sh      <= '0;
            bit_cnt <= '0;
            opcode  <= '0;
            addr    <= '0;
        end else if (bit_stb) begin
            sh <= {sh[30:0], bit_in};
            if (bit_cnt != CNT_MAX) bit_cnt <= bit_cnt + 1'b1;
            if (bit_cnt == AT_OP)  opcode <= {sh[6:0], bit_in};
            if (bit_cnt == AT_ADR) addr   <= {sh[22:0], bit_in};
        end
    end

endmodule

// File: rtl/sfc_protect.sv
module sfc_protect
    import sfc_pkg::*;
#(
    parameter int ARRAY_AW  = 19,
    parameter int SECTOR_AW = 12,
    parameter int BLOCK_AW  = 16
) (
    input  logic [2:0]          bp,
    input  cmd_kind_t           kind,
    input  logic [ARRAY_AW-1:0] addr,
    output logic                hit
);
    localparam logic [ARRAY_AW:0]   ONE      = (ARRAY_AW+1)'(1);
    localparam logic [ARRAY_AW:0]   FULL     = ONE << ARRAY_AW;
    localparam logic [ARRAY_AW-1:0] SEC_MASK = {ARRAY_AW{1'b1}} << SECTOR_AW;
    localparam logic [ARRAY_AW-1:0] BLK_MASK = {ARRAY_AW{1'b1}} << BLOCK_AW;

    logic [ARRAY_AW:0] limit;

    always_comb begin
        if (bp == 3'd0)      limit = '0;
        else if (bp == 3'd7) limit = FULL;
        else                 limit = FULL - (ONE << (SECTOR_AW + int'(bp)));
    end

    always_comb begin
        case (kind)
            K_PROG:   hit = {1'b0, addr} < limit;
            K_SERASE: hit = {1'b0, addr & SEC_MASK} < limit;
            K_BERASE: hit = {1'b0, addr & BLK_MASK} < limit;
            K_CERASE: hit = (bp != 3'd0);
            default:  hit = 1'b0;
        endcase
    end

endmodule

// File: rtl/sfc_judge.sv
module sfc_judge
    import sfc_pkg::*;
#(
    parameter int CNT_W    = 12,
    parameter int NB_W     = 9,
    parameter int MAX_DATA = 256
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cs_hi,
    input  logic             cs_rise,
    input  logic [CNT_W-1:0] bit_cnt,
    input  logic [7:0]       opcode,
    input  logic [23:0]      addr,
    input  logic             busy,
    input  logic             prot_hit,
    output cmd_kind_t        snap_kind,
    output logic [23:0]      snap_addr,
    output logic             exec_stb,
    output cmd_kind_t        exec_kind,
    output logic [23:0]      exec_addr,
    output logic [NB_W-1:0]  exec_nbytes,
    output logic             wel,
    output logic             prot_rej
);
    localparam logic [CNT_W-1:0] C8   = CNT_W'(8);
    localparam logic [CNT_W-1:0] C16  = CNT_W'(16);
    localparam logic [CNT_W-1:0] C32  = CNT_W'(32);
    localparam logic [CNT_W-1:0] C40  = CNT_W'(40);
    localparam logic [CNT_W-1:0] CMAX = CNT_W'(MAX_DATA);

    typedef enum logic [1:0] {ST_IDLE, ST_FRAME, ST_DECIDE} st_t;

    st_t              state, nxt;
    logic [CNT_W-1:0] snap_cnt;
    logic             shape_ok, lock, no_wel, go, refuse;
    logic [CNT_W-1:0] hdr, diff, nb_full;
    logic [NB_W-1:0]  nb;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:   if (!cs_hi)  nxt = ST_FRAME;   // open
            ST_FRAME:  if (cs_rise) nxt = ST_DECIDE;  // close
            ST_DECIDE:              nxt = ST_IDLE;    // retire
            default:                nxt = ST_IDLE;
        endcase
    end

    // frame snapshot at the close transition
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            snap_cnt  <= '0;
            snap_kind <= K_NONE;
            snap_addr <= '0;
        end else if (state == ST_FRAME && cs_rise) begin
            snap_cnt  <= bit_cnt;
            snap_kind <= decode_op(opcode);
            snap_addr <= addr;
        end
    end

    // length rules per command class
    always_comb begin
        shape_ok = 1'b0;
        if (snap_cnt >= C8 && snap_kind != K_NONE) begin
            if (is_strict(snap_kind) && snap_cnt[2:0] != 3'd0) begin
                shape_ok = 1'b0;
            end else begin
                case (snap_kind)
                    K_PROG:             shape_ok = snap_cnt >= C40;
                    K_SERASE, K_BERASE: shape_ok = snap_cnt == C32;
                    K_WSTAT:            shape_ok = snap_cnt >= C16;
                    K_READ, K_FREAD:    shape_ok = snap_cnt >= C32;
                    default:            shape_ok = 1'b1;
                endcase
            end
        end
    end

    always_comb begin
        lock    = busy && is_locked(snap_kind);
        no_wel  = is_write(snap_kind) && !wel;
        go      = shape_ok && !lock && !no_wel && !prot_hit;
        refuse  = shape_ok && !lock && !no_wel && prot_hit;
        hdr     = has_addr(snap_kind) ? C32 : C8;
        diff    = (snap_cnt >= hdr) ? (snap_cnt - hdr) : '0;
        nb_full = diff >> 3;
        nb      = (nb_full > CMAX) ? NB_W'(MAX_DATA) : nb_full[NB_W-1:0];
    end

    // outputs, updated in the retire cycle
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            exec_stb    <= 1'b0;
            exec_kind   <= K_NONE;
            exec_addr   <= '0;
            exec_nbytes <= '0;
            wel         <= 1'b0;
            prot_rej    <= 1'b0;
        end else begin
            exec_stb <= 1'b0;
            if (state == ST_DECIDE) begin
                if (go) begin
                    exec_stb    <= 1'b1;
                    exec_kind   <= snap_kind;
                    exec_addr   <= snap_addr;
                    exec_nbytes <= nb;
                    if (snap_kind == K_WEN) begin
                        wel      <= 1'b1;
                        prot_rej <= 1'b0;
                    end else if (snap_kind == K_WDIS || is_write(snap_kind)) begin
                        wel <= 1'b0;
                    end
                end else if (refuse) begin
                    prot_rej <= 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/serial_cmd_front.sv
module serial_cmd_front
    import sfc_pkg::*;
#(
    parameter int ARRAY_AW    = 19,
    parameter int SECTOR_AW   = 12,
    parameter int BLOCK_AW    = 16,
    parameter int MAX_DATA    = 256,
    parameter int SYNC_STAGES = 2
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            spi_cs_n,
    input  logic                            spi_sclk,
    input  logic                            spi_di,
    input  logic [2:0]                      bp_lvl,
    input  logic                            wr_busy,
    output logic                            exec_stb,
    output logic [3:0]                      exec_op,
    output logic [23:0]                     exec_addr,
    output logic [$clog2(MAX_DATA+1)-1:0]   exec_nbytes,
    output logic                            wel,
    output logic                            prot_reject
);
    localparam int NB_W  = $clog2(MAX_DATA + 1);
    localparam int CNT_W = $clog2((MAX_DATA + 4) * 8 + 8);

    logic             cs_hi, cs_rise, sclk_rise, di_s;
    logic [CNT_W-1:0] bit_cnt;
    logic [7:0]       opcode;
    logic [23:0]      addr;
    cmd_kind_t        snap_kind, exec_kind;
    logic [23:0]      snap_addr;
    logic             prot_hit;

    sfc_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .cs_n      (spi_cs_n),
        .sclk      (spi_sclk),
        .di        (spi_di),
        .cs_hi     (cs_hi),
        .cs_rise   (cs_rise),
        .sclk_rise (sclk_rise),
        .di_s      (di_s)
    );

    sfc_shifter #(.CNT_W(CNT_W)) u_shift (
        .clk     (clk),
        .rst_n   (rst_n),
        .cs_hi   (cs_hi),
        .bit_stb (sclk_rise & ~cs_hi),
        .bit_in  (di_s),
        .bit_cnt (bit_cnt),
        .opcode  (opcode),
        .addr    (addr)
    );

    sfc_protect #(
        .ARRAY_AW  (ARRAY_AW),
        .SECTOR_AW (SECTOR_AW),
        .BLOCK_AW  (BLOCK_AW)
    ) u_prot (
        .bp   (bp_lvl),
        .kind (snap_kind),
        .addr (snap_addr[ARRAY_AW-1:0]),
        .hit  (prot_hit)
    );

    sfc_judge #(
        .CNT_W    (CNT_W),
        .NB_W     (NB_W),
        .MAX_DATA (MAX_DATA)
    ) u_judge (
        .clk         (clk),
        .rst_n       (rst_n),
        .cs_hi       (cs_hi),
        .cs_rise     (cs_rise),
        .bit_cnt     (bit_cnt),
        .opcode      (opcode),
        .addr        (addr),
        .busy        (wr_busy),
        .prot_hit    (prot_hit),
        .snap_kind   (snap_kind),
        .snap_addr   (snap_addr),
        .exec_stb    (exec_stb),
        .exec_kind   (exec_kind),
        .exec_addr   (exec_addr),
        .exec_nbytes (exec_nbytes),
        .wel         (wel),
        .prot_rej    (prot_reject)
    );

    assign exec_op = exec_kind;

endmodule

// File: rtl/sfc_checker.sv
module sfc_checker #(
    parameter int NB_W = 9
) (
    input logic            clk,
    input logic            rst_n,
    input logic            wr_busy,
    input logic [2:0]      bp_lvl,
    input logic            exec_stb,
    input logic [3:0]      exec_op,
    input logic [NB_W-1:0] exec_nbytes,
    input logic            wel,
    input logic            prot_reject
);

    AST_STB_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        exec_stb |=> !exec_stb); // R10

    AST_WEL_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wel) |-> (exec_stb && exec_op == 4'd6)); // R8

    AST_WEL_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(wel) |-> (exec_stb && exec_op inside {[4'd7:4'd12]})); // R8

    AST_WRITE_NEEDS_WEL: assert property (@(posedge clk) disable iff (!rst_n)
        (exec_stb && exec_op inside {[4'd8:4'd12]}) |-> $past(wel)); // R8

    AST_BUSY_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
        (exec_stb && exec_op inside {4'd1, 4'd2, [4'd8:4'd12]}) |-> !$past(wr_busy)); // R7

    AST_REJ_NO_STB: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(prot_reject) |-> !exec_stb); // R9

    AST_REJ_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(prot_reject) |-> (exec_stb && exec_op == 4'd6)); // R9

    AST_FULL_ERASE_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
        (exec_stb && exec_op == 4'd12) |-> ($past(bp_lvl) == 3'd0)); // R9

    AST_ERASE_NO_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        (exec_stb && exec_op inside {4'd10, 4'd11}) |-> (exec_nbytes == '0)); // R5

endmodule

bind serial_cmd_front sfc_checker #(.NB_W($clog2(MAX_DATA + 1))) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_busy     (wr_busy),
    .bp_lvl      (bp_lvl),
    .exec_stb    (exec_stb),
    .exec_op     (exec_op),
    .exec_nbytes (exec_nbytes),
    .wel         (wel),
    .prot_reject (prot_reject)
);

// File: tb/serial_cmd_front_bench.sv
module serial_cmd_front_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cs_n = 1'b1;
    logic        sclk = 1'b0;
    logic        di = 1'b0;
    logic [2:0]  bp = 3'd0;
    logic        busy = 1'b0;
    logic        stb;
    logic [3:0]  op;
    logic [23:0] adr;
    logic [8:0]  nby;
    logic        wel;
    logic        rej;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // bench-side model state
    bit m_wel = 0;
    bit m_rej = 0;

    // strobe monitor
    int          stb_seen = 0;
    logic [3:0]  cap_op;
    logic [23:0] cap_adr;
    logic [8:0]  cap_nb;

    always #10 clk = ~clk;

    serial_cmd_front u_serial_cmd_front (
        .clk         (clk),
        .rst_n       (rst_n),
        .spi_cs_n    (cs_n),
        .spi_sclk    (sclk),
        .spi_di      (di),
        .bp_lvl      (bp),
        .wr_busy     (busy),
        .exec_stb    (stb),
        .exec_op     (op),
        .exec_addr   (adr),
        .exec_nbytes (nby),
        .wel         (wel),
        .prot_reject (rej)
    );

    always @(negedge clk) begin
        if (stb) begin
            stb_seen = stb_seen + 1;
            cap_op   = op;
            cap_adr  = adr;
            cap_nb   = nby;
        end
    end

    task automatic chk(input bit ok, input string tag, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    function automatic int kind_of(input logic [7:0] o);
        case (o)
            8'h03: return 1;
            8'h0B: return 2;
            8'h05: return 3;
            8'hAB: return 4;
            8'h9F: return 5;
            8'h06: return 6;
            8'h04: return 7;
            8'h01: return 8;
            8'h02: return 9;
            8'h20: return 10;
            8'hD8: return 11;
            8'hC7: return 12;
            8'hB9: return 13;
            default: return 0;
        endcase
    endfunction

    function automatic int prot_limit(input int lvl);
        if (lvl == 0) return 0;
        if (lvl == 7) return 'h80000;
        return 'h80000 - ('h1000 << lvl);
    endfunction

    task automatic send(input logic [63:0] v, input int n);
        stb_seen = 0;
        cs_n = 1'b0;
        repeat (4) @(negedge clk);
        for (int i = 0; i < n; i++) begin
            di = v[63-i];
            repeat (3) @(negedge clk);
            sclk = 1'b1;
            repeat (3) @(negedge clk);
            sclk = 1'b0;
        end
        repeat (3) @(negedge clk);
        cs_n = 1'b1;
        di = 1'b0;
        repeat (12) @(negedge clk);
    endtask

    // send one frame and compare with expectations derived from the requirements
    task automatic run(input logic [63:0] v, input int n);
        int    k, nb, hdr, lim, a19, base;
        bit    ok, addressed, wr, strict, locked, hit;
        string tag;
        k         = kind_of(v[63:56]);
        addressed = k inside {1, 2, 9, 10, 11};
        wr        = k inside {[8:12]};
        strict    = wr || (k inside {6, 7, 13});
        locked    = wr || (k inside {1, 2});
        ok        = (n >= 8) && (k != 0);
        tag       = "R2";
        if (!ok) tag = "R11";
        else if (strict && (n % 8) != 0) begin
            ok  = 0;
            tag = (k == 9) ? "R3 R13" : "R3";
        end else begin
            case (k)
                9:       begin ok = n >= 40; tag = "R4"; end
                8:       begin ok = n >= 16; tag = "R4"; end
                10, 11:  begin ok = n == 32; tag = "R5"; end
                1, 2:    begin ok = n >= 32; tag = "R6"; end
                3, 4, 5: tag = "R6";
                6, 7:    tag = "R8";
                default: tag = "R2";
            endcase
        end
        if (ok && busy && locked) begin ok = 0; tag = "R7"; end
        if (ok && wr && !m_wel)  begin ok = 0; tag = "R8"; end
        lim = prot_limit(int'(bp));
        a19 = int'(v[50:32]);
        case (k)
            9:  hit = a19 < lim;
            10: begin base = a19 & ~'hFFF;  hit = base < lim; end
            11: begin base = a19 & ~'hFFFF; hit = base < lim; end
            12: hit = bp != 3'd0;
            default: hit = 0;
        endcase
        if (ok && hit) begin ok = 0; m_rej = 1; tag = "R9"; end
        if (ok) begin
            if (k == 6) begin m_wel = 1; m_rej = 0; end
            else if (k == 7 || wr) m_wel = 0;
        end
        hdr = addressed ? 32 : 8;
        nb  = (n >= hdr) ? (n - hdr) / 8 : 0;

        send(v, n);

        chk(stb_seen == (ok ? 1 : 0), {tag, " R10"}, "strobe count", stb_seen, ok ? 1 : 0);
        if (ok && stb_seen == 1) begin
            chk(cap_op == 4'(k), {tag, " R2"}, "exec_op", cap_op, k);
            chk(cap_nb == 9'(nb), {tag, " R4"}, "exec_nbytes", cap_nb, nb);
            if (addressed)
                chk(cap_adr == v[55:32], {tag, " R1"}, "exec_addr", cap_adr, v[55:32]);
        end
        chk(wel == m_wel, {tag, " R8"}, "wel", wel, m_wel);
        chk(rej == m_rej, {tag, " R9"}, "prot_reject", rej, m_rej);
    endtask

    task automatic set_latch(input bit val);
        run({val ? 8'h06 : 8'h04, 56'h0}, 8);
    endtask

    initial begin
        logic [7:0] ops [15];
        int         lens [9];
        ops  = '{8'h03, 8'h0B, 8'h05, 8'hAB, 8'h9F, 8'h06, 8'h04, 8'h01,
                 8'h02, 8'h20, 8'hD8, 8'hC7, 8'hB9, 8'h00, 8'hFF};
        lens = '{7, 8, 12, 16, 32, 33, 40, 47, 64};

        repeat (5) @(negedge clk);
        // R12: reset state
        chk(stb == 1'b0, "R12", "exec_stb", stb, 0);
        chk(op == 4'd0, "R12", "exec_op", op, 0);
        chk(adr == 24'd0, "R12", "exec_addr", adr, 0);
        chk(nby == 9'd0, "R12", "exec_nbytes", nby, 0);
        chk(wel == 1'b0, "R12", "wel", wel, 0);
        chk(rej == 1'b0, "R12", "prot_reject", rej, 0);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);

        // R13: program cut off mid-byte leaves the latch set
        set_latch(1);
        run({8'h02, 24'h012345, 32'hA5A5_5A5A}, 45);
        chk(wel == 1'b1, "R13", "wel after partial program", wel, 1);

        // R1: bit order of the captured address
        run({8'h03, 24'h5A3C81, 32'h0}, 40);

        // sweep of opcodes by frame length by latch state (R2 R3 R4 R5 R6 R8 R11)
        for (int oi = 0; oi < 15; oi++) begin
            for (int li = 0; li < 9; li++) begin
                for (int w = 0; w < 2; w++) begin
                    logic [23:0] a;
                    a = 24'h1357_9B ^ 24'(oi * 24'h0F1D3 + li * 24'h2461);
                    set_latch(w[0]);
                    run({ops[oi], a, 32'hC3A5_0F96}, lens[li]);
                end
            end
        end

        // R7: busy lockout
        busy = 1'b1;
        repeat (4) @(negedge clk);
        for (int oi = 0; oi < 15; oi++) begin
            for (int li = 0; li < 3; li++) begin
                int n;
                n = (li == 0) ? 8 : (li == 1) ? 32 : 40;
                set_latch(1);
                run({ops[oi], 24'h070000, 32'h1122_3344}, n);
            end
        end
        busy = 1'b0;
        repeat (4) @(negedge clk);

        // R9: every protect level against addresses around the limit
        for (int lv = 0; lv < 8; lv++) begin
            bp = 3'(lv);
            repeat (4) @(negedge clk);
            for (int ai = 0; ai < 4; ai++) begin
                int lim, av;
                lim = prot_limit(lv);
                case (ai)
                    0: av = 0;
                    1: av = (lim - 1) & 'h7FFFF;
                    2: av = lim & 'h7FFFF;
                    default: av = 'h7FFFF;
                endcase
                set_latch(1);
                run({8'h02, 24'(av), 32'hDEAD_BEEF}, 40);
                set_latch(1);
                run({8'h20, 24'(av), 32'h0}, 32);
                set_latch(1);
                run({8'hD8, 24'(av), 32'h0}, 32);
                set_latch(1);
                run({8'hC7, 56'h0}, 8);
            end
        end

        if (!done) begin
            done = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++;
            errors++;
            $display("FAIL R10 watchdog actual=expired expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule